// File: doc/BRIEF.md
# Direction-Switched Shared Data FIFO

This block is one 32-bit by 32-word buffer shared by the two directions of a data path. Two activity inputs from the data-path unit choose the direction. With transmit activity, the host bus fills the buffer and the data-path unit drains it. With receive activity, the data-path unit fills it and the host bus drains it. With neither input, or with both, the buffer is off.

A registered output word always shows the entry at the read pointer. The data-path unit signals "shift register loaded" to advance the pointer in transmit mode. The activity inputs and the data-path strobes come from the card clock domain. Two-flop synchronizers carry the activity levels into the bus clock domain. Toggle-to-pulse synchronizers carry the strobes.

While the buffer is off, all status outputs are low and both pointers and the occupancy are held at zero.

Top module: `dir_fifo`

## Requirements
- R1: The buffer holds 32 words of 32 bits. Words leave in the order they entered.
- R2: Mode selection uses the synchronized activity levels:
  - transmit when only `tx_act_i` is high;
  - receive when only `rx_act_i` is high;
  - off otherwise.
  A bus write outside transmit mode is ignored, and so is a bus read outside receive mode.
- R3: `data_o` shows the word at the read pointer one clock after the pointer or that entry changes.
- R4: In transmit mode, each data-path pull advances the read pointer by one word.
- R5: In receive mode, each data-path push stores `dp_wdata_i`, and each `bus_rd_i` cycle advances the read pointer.
- R6: While off, every status output is 0 and both pointers and the occupancy are 0. On re-entry to a mode the buffer starts empty.
- R7: An activity change reaches the mode logic after two clock edges. A bus write in the first clock after `tx_act_i` rises is ignored.
- R8: A transmit write goes into the buffer for every value of `bus_addr_i` (32 word addresses).
- R9: The level flags depend on the occupancy:
  - `empty_o` is high at 0 words and `avail_o` above 0 words;
  - `half_o` is high at 16 or more words;
  - `full_o` is high at 32 words.
- R10: A push while full is dropped and sets the sticky `ovr_o`. A pull while empty is dropped and sets the sticky `udr_o`. Both clear only while off.
- R11: Each level change of `dp_pull_tgl_i` or `dp_push_tgl_i` counts as exactly one strobe. The strobe acts on the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_act_i | input | 1 | Transmit activity level from the card clock domain |
| rx_act_i | input | 1 | Receive activity level from the card clock domain |
| bus_wr_i | input | 1 | Host bus write strobe |
| bus_addr_i | input | 5 | Host bus word address inside the FIFO window |
| bus_wdata_i | input | 32 | Host bus write data |
| bus_rd_i | input | 1 | Host bus read strobe; pops the word shown on `data_o` |
| dp_push_tgl_i | input | 1 | Data-path push strobe, toggle-coded |
| dp_wdata_i | input | 32 | Data-path write data, held stable around a push toggle |
| dp_pull_tgl_i | input | 1 | Data-path shift-register-loaded strobe, toggle-coded |
| data_o | output | 32 | Registered word at the read pointer |
| full_o | output | 1 | Occupancy is 32 |
| empty_o | output | 1 | Occupancy is 0 while enabled |
| half_o | output | 1 | Occupancy is 16 or more |
| avail_o | output | 1 | At least one word is present |
| ovr_o | output | 1 | Sticky overrun error |
| udr_o | output | 1 | Sticky underrun error |

## Verification
Checked on every cycle by the assertions:
- all flags stay low while the buffer is off;
- `full_o` and `empty_o` are never high together, and `full_o` implies `half_o`;
- `empty_o` and `avail_o` are complementary while enabled;
- the occupancy moves by at most one word per cycle;
- the error flags stay set until the buffer is switched off.

Only the bench scenarios can show the following:
- word ordering through a full fill and drain;
- the value on `data_o` after each pull or read;
- the exact number of cycles each synchronizer adds;
- that an early write is lost;
- that the buffer restarts empty after it has been off.

// File: rtl/dir_fifo_pkg.sv
package dir_fifo_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RX  = 2'd2
  } fifo_mode_e;
endpackage

// File: rtl/dir_fifo_sync.sv
module dir_fifo_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/dir_fifo_tgl.sv
module dir_fifo_tgl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic sync_q, last_q;
  dir_fifo_sync #(.W(1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgl_i),
    .q_o   (sync_q)
  );
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q;
  end
  assign pulse_o = sync_q ^ last_q;
endmodule

// File: rtl/dir_fifo_core.sv
module dir_fifo_core #(
  parameter int DW = 32,
  parameter int DEPTH = 32,
  parameter int AW = $clog2(DEPTH),
  parameter int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          half_o,
  output logic          avail_o,
  output logic          ovr_o,
  output logic          udr_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovr_q, udr_q, is_full, is_empty, do_push, do_pop;
  logic [DW-1:0] rdata_q;

  assign is_full  = (cnt_q == FULL_CNT);
  assign is_empty = (cnt_q == '0);
  assign do_push  = en_i && push_i && !is_full;
  assign do_pop   = en_i && pop_i && !is_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else if (!en_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && is_full) ovr_q <= 1'b1;
      if (pop_i && is_empty) udr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  // prefetched output word, one cycle behind pointer or entry change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= mem_q[rptr_q];
  end

  assign rdata_o = rdata_q;
  assign cnt_o   = cnt_q;
  assign full_o  = en_i && is_full;
  assign empty_o = en_i && is_empty;
  assign half_o  = en_i && (cnt_q >= HALF_CNT);
  assign avail_o = en_i && !is_empty;
  assign ovr_o   = en_i && ovr_q;
  assign udr_o   = en_i && udr_q;
endmodule

// File: rtl/dir_fifo.sv
module dir_fifo
  import dir_fifo_pkg::*;
#(
  parameter int DW = 32,
  parameter int DEPTH = 32,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_act_i,
  input  logic          rx_act_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic          bus_rd_i,
  input  logic          dp_push_tgl_i,
  input  logic [DW-1:0] dp_wdata_i,
  input  logic          dp_pull_tgl_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          half_o,
  output logic          avail_o,
  output logic          ovr_o,
  output logic          udr_o
);
  localparam int CW = AW + 1;

  logic [1:0]    act_s;
  logic          dp_push, dp_pull, push, pop;
  logic [DW-1:0] wdata;
  logic [CW-1:0] cnt;
  fifo_mode_e    mode;
  logic          unused_addr;

  // whole window maps onto the FIFO
  assign unused_addr = ^bus_addr_i;

  dir_fifo_sync #(.W(2)) u_act_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rx_act_i, tx_act_i}),
    .q_o   (act_s)
  );

  dir_fifo_tgl u_push_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgl_i  (dp_push_tgl_i),
    .pulse_o(dp_push)
  );

  dir_fifo_tgl u_pull_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgl_i  (dp_pull_tgl_i),
    .pulse_o(dp_pull)
  );

  always_comb begin
    unique case (act_s)
      2'b01:   mode = MODE_TX;
      2'b10:   mode = MODE_RX;
      default: mode = MODE_OFF;
    endcase
  end

  always_comb begin
    push  = 1'b0;
    pop   = 1'b0;
    wdata = bus_wdata_i;
    unique case (mode)
      MODE_TX: begin
        push = bus_wr_i;
        pop  = dp_pull;
      end
      MODE_RX: begin
        push  = dp_push;
        pop   = bus_rd_i;
        wdata = dp_wdata_i;
      end
      default: ;
    endcase
  end

  dir_fifo_core #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode != MODE_OFF),
    .push_i (push),
    .wdata_i(wdata),
    .pop_i  (pop),
    .rdata_o(data_o),
    .cnt_o  (cnt),
    .full_o (full_o),
    .empty_o(empty_o),
    .half_o (half_o),
    .avail_o(avail_o),
    .ovr_o  (ovr_o),
    .udr_o  (udr_o)
  );
endmodule

// File: rtl/dir_fifo_chk.sv
module dir_fifo_chk
  import dir_fifo_pkg::*;
#(
  parameter int CW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input fifo_mode_e    mode,
  input logic [CW-1:0] cnt,
  input logic          full_o,
  input logic          empty_o,
  input logic          half_o,
  input logic          avail_o,
  input logic          ovr_o,
  input logic          udr_o
);
  a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_OFF) |-> !(full_o || empty_o || half_o || avail_o || ovr_o || udr_o));

  a_r9_full_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r9_full_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o);

  a_r9_empty_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_OFF) |-> (empty_o != avail_o));

  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_OFF) |=> (mode == MODE_OFF) || (cnt == $past(cnt)) ||
      (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt)));

  a_r10_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o || (mode == MODE_OFF));

  a_r10_udr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udr_o |=> udr_o || (mode == MODE_OFF));
endmodule

bind dir_fifo dir_fifo_chk #(.CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode   (mode),
  .cnt    (cnt),
  .full_o (full_o),
  .empty_o(empty_o),
  .half_o (half_o),
  .avail_o(avail_o),
  .ovr_o  (ovr_o),
  .udr_o  (udr_o)
);

// File: tb/tb_dir_fifo.sv
module tb_dir_fifo;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tx_act_i = 0, rx_act_i = 0, bus_wr_i = 0, bus_rd_i = 0;
  logic [4:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, dp_wdata_i = '0, data_o;
  logic        dp_push_tgl_i = 0, dp_pull_tgl_i = 0;
  logic        full_o, empty_o, half_o, avail_o, ovr_o, udr_o;
  int          n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  dir_fifo dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] flags();
    return {full_o, empty_o, half_o, avail_o, ovr_o, udr_o};
  endfunction

  task automatic bwrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 0;
  endtask

  task automatic bread();
    @(negedge clk_i); bus_rd_i = 1;
    @(negedge clk_i); bus_rd_i = 0;
    @(negedge clk_i);
  endtask

  task automatic pull();
    @(negedge clk_i); dp_pull_tgl_i = ~dp_pull_tgl_i;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic dpush(logic [31:0] d);
    @(negedge clk_i); dp_wdata_i = d; dp_push_tgl_i = ~dp_push_tgl_i;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic set_mode(logic tx, logic rx);
    @(negedge clk_i); tx_act_i = tx; rx_act_i = rx;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R6 reset flags", 32'(flags()), 32'h0);
  endtask

  task automatic t_sync();
    // write in first clock after tx rises must be lost
    @(negedge clk_i);
    tx_act_i = 1; bus_wr_i = 1; bus_wdata_i = 32'hDEAD0000;
    @(negedge clk_i);
    bus_wr_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R7 early write dropped", {31'd0, empty_o}, 32'd1);
    set_mode(0, 0);
  endtask

  task automatic t_tx();
    set_mode(1, 0);
    chk("R9 empty on entry", 32'(flags()), 32'b010000);
    for (int i = 0; i < 32; i++) begin
      bwrite(5'(31 - i), 32'hA500_0000 + 32'(i));
      if (i == 14) chk("R9 half below 16", {31'd0, half_o}, 32'd0);
      if (i == 15) chk("R9 half at 16", {31'd0, half_o}, 32'd1);
    end
    chk("R8 R1 full after 32 writes", 32'(flags()), 32'b101100);
    @(negedge clk_i);
    chk("R3 data_o first word", data_o, 32'hA500_0000);
    bwrite(5'd0, 32'hBAD0BAD0);
    chk("R10 overrun set", {31'd0, ovr_o}, 32'd1);
    chk("R10 full kept", {31'd0, full_o}, 32'd1);
    for (int i = 1; i < 32; i++) begin
      pull();
      chk("R4 R11 R1 pulled order", data_o, 32'hA500_0000 + 32'(i));
    end
    pull();
    chk("R4 drained empty", 32'(flags()), 32'b010010);
    pull();
    chk("R10 underrun set", {31'd0, udr_o}, 32'd1);
    chk("R10 overrun sticky", {31'd0, ovr_o}, 32'd1);
    bread();
    chk("R2 bus read ignored in tx", {31'd0, empty_o}, 32'd1);
  endtask

  task automatic t_disable();
    bwrite(5'd3, 32'h1111_1111);
    set_mode(0, 0);
    chk("R6 off flags low", 32'(flags()), 32'h0);
    set_mode(1, 0);
    chk("R6 reentry empty no errors", 32'(flags()), 32'b010000);
    bwrite(5'd9, 32'h2222_2222);
    @(negedge clk_i);
    chk("R6 pointers reset", data_o, 32'h2222_2222);
    set_mode(1, 1);
    chk("R2 both active is off", 32'(flags()), 32'h0);
    set_mode(0, 0);
  endtask

  task automatic t_rx();
    set_mode(0, 1);
    bwrite(5'd1, 32'hFFFF_0001);
    chk("R2 bus write ignored in rx", {31'd0, empty_o}, 32'd1);
    pull();
    chk("R2 pull ignored in rx", {31'd0, udr_o}, 32'd0);
    dpush(32'hC0DE_0001);
    dpush(32'hC0DE_0002);
    dpush(32'hC0DE_0003);
    chk("R5 R11 three pushes", 32'(flags()), 32'b000100);
    chk("R5 head word", data_o, 32'hC0DE_0001);
    bread();
    chk("R5 second word", data_o, 32'hC0DE_0002);
    bread();
    chk("R5 third word", data_o, 32'hC0DE_0003);
    bread();
    chk("R5 rx drained", 32'(flags()), 32'b010000);
    set_mode(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_sync();
    t_tx();
    t_disable();
    t_rx();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule